// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits at the output of a 14-bit sampling converter. It replaces the live sample word with a known test word, one word for each sample the converter delivers. A 4-bit select picks one of thirteen behaviours. With the select at zero, the live data passes straight through. The other codes give fixed levels, alternating words, two pseudo-random bit sequences, a marching single bit, a word with mixed toggle rates, a one-time sync marker, and a player for two user-supplied words.

The sample clock is `clk`, and `sampleEn` marks the cycles that carry a sample. The output register loads only on those cycles. Every sequencing counter and both pseudo-random generators step only on a sample. `outValid` reports whether the last clock loaded a word. When the select changes, the sequence restarts: the first sample taken under the new select is word index 0 of its pattern. This holds whether or not a sample arrives in the clock where the change is first seen.

Top module: `testword_gen`

## Requirements
- R1: After reset, `outData` is 0x0000 and `outValid` is 0. With select 0000, each sample loads `liveData` unchanged into `outData`.
- R2: A clock with `sampleEn` high loads `outData` and sets `outValid` on that edge. A clock with `sampleEn` low clears `outValid`, holds `outData`, and advances no pattern state.
- R3: Select 0001 gives 0x2000, 0010 gives 0x3FFF and 0011 gives 0x0000, all in offset binary.
- R4: Select 0100 gives 0x2AAA at even word indices and 0x1555 at odd word indices. Word index n counts the samples taken since the select last changed, starting from 0.
- R5: Select 0111 gives 0x3FFF at even n and 0x0000 at odd n. Select 1001 gives 0x3333 at even n and 0x0CCC at odd n.
- R6: Select 0101 plays the long sequence from a 23-bit shift register. On each sample the register shifts left one place, and the bit shifted in is bit 22 XOR bit 17 (x^23+x^18+1). The output word is bits 13:0 of the new register value.
- R7: Select 0110 plays the short sequence from a 14-bit shift history. On each sample it shifts left one place, and the bit shifted in is bit 8 XOR bit 4 (x^9+x^5+1). The output word is the new 14-bit value.
- R8: Each generator starts all ones after reset. A clock with its own reset input high reloads it to all ones, and in that clock the output word is 0x3FFF. A generator steps only on samples while its own code is selected. Its reset input does not affect the other generator.
- R9: Select 1010 gives 0x3FFF for n = 0 and 0x0000 for every later sample.
- R10: Select 1011 gives a word with only bit (n mod 14) set.
- R11: Select 1100 gives a word in which bit k equals bit (k mod 3) of (n mod 8).
- R12: Select 1000 plays the user words A and B as set by the mode. Mode 00 gives A on every sample. Mode 01 gives A at even n and B at odd n. Mode 10 gives A at n = 0 and 0x0000 after that. Mode 11 gives A, then B, then 0x0000. A mode change alone does not restart n.
- R13: Select codes 1101 to 1111 give 0x0000. A select change restarts n at 0 for the first sample taken under the new select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | High in cycles that carry a sample |
| liveData | input | 14 | Normal converter output word |
| patSel | input | 4 | Pattern select |
| pnLongRst | input | 1 | Reload the long generator to all ones |
| pnShortRst | input | 1 | Reload the short generator to all ones |
| userMode | input | 2 | User word sequencing mode |
| userWordA | input | 14 | First user word |
| userWordB | input | 14 | Second user word |
| outData | output | 14 | Selected output word |
| outValid | output | 1 | High when the last clock loaded a word |

## Verification
Wrong internal state reaches the ports quickly. A wrong alternation phase or word index corrupts the very next sample of any alternating, marching, mixed or user pattern. A skipped restart shows on the first sample after a select change. A generator that stepped on the wrong cycle, or failed to reload, stays out of step for every later word of its sequence until it is reloaded. A word held or loaded on the wrong cycle shows on `outValid` and `outData` one clock after the sample.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [3:0] {
    SEL_LIVE    = 4'b0000,
    SEL_MID     = 4'b0001,
    SEL_POSFS   = 4'b0010,
    SEL_NEGFS   = 4'b0011,
    SEL_CHECKER = 4'b0100,
    SEL_PNLONG  = 4'b0101,
    SEL_PNSHORT = 4'b0110,
    SEL_WORDTOG = 4'b0111,
    SEL_USER    = 4'b1000,
    SEL_BITTOG  = 4'b1001,
    SEL_SYNC    = 4'b1010,
    SEL_WALK    = 4'b1011,
    SEL_MIXED   = 4'b1100
  } patSel_e;

  typedef enum logic [1:0] {
    USR_SINGLE      = 2'b00,
    USR_ALT         = 2'b01,
    USR_SINGLE_ONCE = 2'b10,
    USR_ALT_ONCE    = 2'b11
  } usrMode_e;

  localparam int unsigned LONG_LEN  = 23;
  localparam int unsigned LONG_TAP  = 18;
  localparam int unsigned SHORT_LEN = 9;
  localparam int unsigned SHORT_TAP = 5;
  localparam int unsigned WALK_W    = 5;
  localparam int unsigned TICK_W    = 3;

  // Control to datapath: the sample strobe and the effective word index views
  typedef struct packed {
    logic              advance;
    logic [TICK_W-1:0] tick;
    logic [WALK_W-1:0] walkIdx;
    logic [1:0]        seen;
  } seqCtl_t;

endpackage

// File: rtl/tpg_pn_shifter.sv
module tpg_pn_shifter #(
  parameter int unsigned LEN   = 23,
  parameter int unsigned TAP   = 18,
  parameter int unsigned OUT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedReq,
  input  logic             stepEn,
  output logic [OUT_W-1:0] word
);
  localparam int unsigned REG_W = (LEN > OUT_W) ? LEN : OUT_W;

  logic [REG_W-1:0] state;
  logic [REG_W-1:0] nxt;
  logic             fb;

  assign fb = state[LEN-1] ^ state[TAP-1];

  always_comb begin
    if (seedReq)     nxt = '1;
    else if (stepEn) nxt = {state[REG_W-2:0], fb};
    else             nxt = state;
  end

  assign word = nxt[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) state <= '1;
    else       state <= nxt;
  end

  // R8: a generator seeded with all ones never falls into the all-zero lockup
  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> state != '0);

  // R8: a reload request puts all ones back into the register
  a_r8_seed_loads: assert property (@(posedge clk) disable iff (!rstN)
    seedReq |=> state == '1);

  // R8: the register does not move without a step or a reload
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    !seedReq && !stepEn |=> $stable(state));

endmodule

// File: rtl/tpg_ctrl.sv
module tpg_ctrl
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleEn,
  input  logic [3:0]  patSel,
  output seqCtl_t     seq
);
  localparam logic [WALK_W-1:0] WALK_MAX = WALK_W'(DATA_W - 1);

  logic [3:0]        prevSel;
  logic [TICK_W-1:0] tickQ;
  logic [WALK_W-1:0] walkQ;
  logic [1:0]        seenQ;
  logic              restart;
  logic [TICK_W-1:0] tickEff;
  logic [WALK_W-1:0] walkEff;
  logic [1:0]        seenEff;

  assign restart = (patSel != prevSel);
  assign tickEff = restart ? '0 : tickQ;
  assign walkEff = restart ? '0 : walkQ;
  assign seenEff = restart ? '0 : seenQ;

  assign seq.advance = sampleEn;
  assign seq.tick    = tickEff;
  assign seq.walkIdx = walkEff;
  assign seq.seen    = seenEff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSel <= '0;
      tickQ   <= '0;
      walkQ   <= '0;
      seenQ   <= '0;
    end else begin
      prevSel <= patSel;
      if (sampleEn) begin
        tickQ <= tickEff + TICK_W'(1);
        walkQ <= (walkEff == WALK_MAX) ? '0 : walkEff + WALK_W'(1);
        seenQ <= (seenEff == 2'd2) ? 2'd2 : seenEff + 2'd1;
      end else if (restart) begin
        tickQ <= '0;
        walkQ <= '0;
        seenQ <= '0;
      end
    end
  end

  initial begin
    a_r10_width_fits: assert (DATA_W >= 2 && DATA_W <= (1 << WALK_W));
  end

  // R13: a select change without a sample still clears the word index
  a_r13_restart_idle: assert property (@(posedge clk) disable iff (!rstN)
    restart && !sampleEn |=> (tickQ == '0 && walkQ == '0 && seenQ == '0));

  // R2: no sample and no change leaves the sequencing state alone
  a_r2_counters_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn && !restart |=> ($stable(tickQ) && $stable(walkQ) && $stable(seenQ)));

  // R10: the marching bit index wraps after the top bit
  a_r10_walk_wrap: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn && walkEff == WALK_MAX |=> walkQ == '0);

  // R10: the marching index stays inside the word
  a_r10_walk_range: assert property (@(posedge clk) disable iff (!rstN)
    walkQ <= WALK_MAX);

endmodule

// File: rtl/tpg_datapath.sv
module tpg_datapath
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           seq,
  input  logic [3:0]        patSel,
  input  logic [1:0]        userMode,
  input  logic [DATA_W-1:0] liveData,
  input  logic [DATA_W-1:0] userWordA,
  input  logic [DATA_W-1:0] userWordB,
  input  logic              pnLongRst,
  input  logic              pnShortRst,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  localparam logic [DATA_W-1:0] MID_WORD  = DATA_W'(1) << (DATA_W - 1);
  localparam logic [DATA_W-1:0] FULL_WORD = '1;

  logic [DATA_W-1:0] checkWord;
  logic [DATA_W-1:0] pairWord;
  logic [DATA_W-1:0] walkWord;
  logic [DATA_W-1:0] mixWord;
  logic [DATA_W-1:0] longWord;
  logic [DATA_W-1:0] shortWord;
  logic [DATA_W-1:0] userWord;
  logic [DATA_W-1:0] nextWord;
  logic              oddWord;

  assign oddWord = seq.tick[0];

  // Fixed bit layouts for the alternating, marching and mixed-rate words
  for (genvar k = 0; k < DATA_W; k++) begin : g_bits
    assign checkWord[k] = (k % 2 == 1);
    assign pairWord[k]  = (k % 4 < 2);
    assign walkWord[k]  = (seq.walkIdx == WALK_W'(k));
    assign mixWord[k]   = seq.tick[k % 3];
  end

  // The two sequence generators differ only in length and feedback tap
  for (genvar g = 0; g < 2; g++) begin : g_pn
    localparam int unsigned LEN  = (g == 0) ? LONG_LEN : SHORT_LEN;
    localparam int unsigned TAP  = (g == 0) ? LONG_TAP : SHORT_TAP;
    localparam logic [3:0]  CODE = (g == 0) ? SEL_PNLONG : SEL_PNSHORT;
    logic [DATA_W-1:0] genWord;

    tpg_pn_shifter #(
      .LEN   (LEN),
      .TAP   (TAP),
      .OUT_W (DATA_W)
    ) pn_i (
      .clk     (clk),
      .rstN    (rstN),
      .seedReq ((g == 0) ? pnLongRst : pnShortRst),
      .stepEn  (seq.advance && (patSel == CODE)),
      .word    (genWord)
    );

    if (g == 0) begin : g_long
      assign longWord = genWord;
    end else begin : g_short
      assign shortWord = genWord;
    end
  end

  always_comb begin
    case (userMode)
      USR_SINGLE:      userWord = userWordA;
      USR_ALT:         userWord = oddWord ? userWordB : userWordA;
      USR_SINGLE_ONCE: userWord = (seq.seen == 2'd0) ? userWordA : '0;
      default:         userWord = (seq.seen == 2'd0) ? userWordA :
                                  (seq.seen == 2'd1) ? userWordB : '0;
    endcase
  end

  always_comb begin
    case (patSel)
      SEL_LIVE:    nextWord = liveData;
      SEL_MID:     nextWord = MID_WORD;
      SEL_POSFS:   nextWord = FULL_WORD;
      SEL_NEGFS:   nextWord = '0;
      SEL_CHECKER: nextWord = oddWord ? ~checkWord : checkWord;
      SEL_PNLONG:  nextWord = longWord;
      SEL_PNSHORT: nextWord = shortWord;
      SEL_WORDTOG: nextWord = oddWord ? '0 : FULL_WORD;
      SEL_USER:    nextWord = userWord;
      SEL_BITTOG:  nextWord = oddWord ? ~pairWord : pairWord;
      SEL_SYNC:    nextWord = (seq.seen == 2'd0) ? FULL_WORD : '0;
      SEL_WALK:    nextWord = walkWord;
      SEL_MIXED:   nextWord = mixWord;
      default:     nextWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= seq.advance;
      if (seq.advance) outData <= nextWord;
    end
  end

  // R1: pass-through is exact, one clock after the sample
  a_r1_passthru: assert property (@(posedge clk) disable iff (!rstN)
    seq.advance && patSel == SEL_LIVE |=> outData == $past(liveData));

  // R2: the valid flag follows the sample strobe by one clock
  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rstN)
    seq.advance |=> outValid);

  // R2: no sample means no valid and a held word
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !seq.advance |=> (!outValid && $stable(outData)));

  // R3: the positive full-scale code fills every bit
  a_r3_posfs: assert property (@(posedge clk) disable iff (!rstN)
    seq.advance && patSel == SEL_POSFS |=> outData == FULL_WORD);

  // R10: the marching pattern has exactly one bit set
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rstN)
    seq.advance && patSel == SEL_WALK |=> $countones(outData) == 1);

  // R12: the once modes go quiet after their words have been played
  a_r12_once_quiet: assert property (@(posedge clk) disable iff (!rstN)
    seq.advance && patSel == SEL_USER && userMode[1] && seq.seen == 2'd2
    |=> outData == '0);

endmodule

// File: rtl/testword_gen.sv
module testword_gen
  import tpg_pkg::*;
#(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic [DATA_W-1:0] liveData,
  input  logic [3:0]        patSel,
  input  logic              pnLongRst,
  input  logic              pnShortRst,
  input  logic [1:0]        userMode,
  input  logic [DATA_W-1:0] userWordA,
  input  logic [DATA_W-1:0] userWordB,
  output logic [DATA_W-1:0] outData,
  output logic              outValid
);
  seqCtl_t seq;

  tpg_ctrl #(
    .DATA_W (DATA_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .patSel   (patSel),
    .seq      (seq)
  );

  tpg_datapath #(
    .DATA_W (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .seq        (seq),
    .patSel     (patSel),
    .userMode   (userMode),
    .liveData   (liveData),
    .userWordA  (userWordA),
    .userWordB  (userWordB),
    .pnLongRst  (pnLongRst),
    .pnShortRst (pnShortRst),
    .outData    (outData),
    .outValid   (outValid)
  );

endmodule

// File: tb/testword_gen_tb_top.sv
`timescale 1ns/1ps
module testword_gen_tb_top;
  localparam int W = 14;
  localparam realtime HALF = 2.0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sampleEn = 1'b0;
  logic [W-1:0] liveData = '0;
  logic [3:0]   patSel = '0;
  logic         pnLongRst = 1'b0;
  logic         pnShortRst = 1'b0;
  logic [1:0]   userMode = '0;
  logic [W-1:0] userWordA = '0;
  logic [W-1:0] userWordB = '0;
  logic [W-1:0] outData;
  logic         outValid;

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state, kept from the requirements alone
  logic [3:0]   mPrevSel = '0;
  int           mN = 0;
  logic [22:0]  mLong = '1;
  logic [13:0]  mShort = '1;
  logic [W-1:0] expData = '0;
  logic         expValid = 1'b0;

  always #(HALF) clk = ~clk;

  testword_gen #(.DATA_W(W)) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleEn   (sampleEn),
    .liveData   (liveData),
    .patSel     (patSel),
    .pnLongRst  (pnLongRst),
    .pnShortRst (pnShortRst),
    .userMode   (userMode),
    .userWordA  (userWordA),
    .userWordB  (userWordB),
    .outData    (outData),
    .outValid   (outValid)
  );

  function automatic string tagOf(input logic [3:0] s);
    case (s)
      4'd0:                tagOf = "R1";
      4'd1, 4'd2, 4'd3:    tagOf = "R3";
      4'd4:                tagOf = "R4";
      4'd7, 4'd9:          tagOf = "R5";
      4'd5:                tagOf = "R6/R8";
      4'd6:                tagOf = "R7/R8";
      4'd8:                tagOf = "R12";
      4'd10:               tagOf = "R9";
      4'd11:               tagOf = "R10";
      4'd12:               tagOf = "R11";
      default:             tagOf = "R13";
    endcase
  endfunction

  function automatic logic [W-1:0] mixOf(input int n);
    logic [W-1:0] w;
    for (int k = 0; k < W; k++) w[k] = 1'((n % 8) >> (k % 3));
    return w;
  endfunction

  task automatic step(input logic en, input logic [3:0] sel, input logic [1:0] um,
                      input logic lr, input logic sr,
                      input logic [W-1:0] live, input logic [W-1:0] a,
                      input logic [W-1:0] b, input int idx);
    int n;
    logic [22:0] nLong;
    logic [13:0] nShort;
    sampleEn = en; patSel = sel; userMode = um; pnLongRst = lr; pnShortRst = sr;
    liveData = live; userWordA = a; userWordB = b;
    // R13: the word index restarts when the select differs from the last clock
    n = (sel != mPrevSel) ? 0 : mN;
    nLong  = lr ? '1 : (en && sel == 4'd5) ? {mLong[21:0], mLong[22] ^ mLong[17]} : mLong;
    nShort = sr ? '1 : (en && sel == 4'd6) ? {mShort[12:0], mShort[8] ^ mShort[4]} : mShort;
    if (en) begin
      case (sel)
        4'd0:  expData = live;
        4'd1:  expData = 14'h2000;
        4'd2:  expData = 14'h3FFF;
        4'd3:  expData = 14'h0000;
        4'd4:  expData = (n % 2 == 0) ? 14'h2AAA : 14'h1555;
        4'd5:  expData = nLong[13:0];
        4'd6:  expData = nShort;
        4'd7:  expData = (n % 2 == 0) ? 14'h3FFF : 14'h0000;
        4'd8: begin
          case (um)
            2'd0: expData = a;
            2'd1: expData = (n % 2 == 0) ? a : b;
            2'd2: expData = (n == 0) ? a : '0;
            default: expData = (n == 0) ? a : (n == 1) ? b : '0;
          endcase
        end
        4'd9:  expData = (n % 2 == 0) ? 14'h3333 : 14'h0CCC;
        4'd10: expData = (n == 0) ? 14'h3FFF : 14'h0000;
        4'd11: expData = 14'(1) << (n % 14);
        4'd12: expData = mixOf(n);
        default: expData = '0;
      endcase
      mN = n + 1;
    end else begin
      mN = n;
    end
    expValid = en;
    mLong = nLong;
    mShort = nShort;
    mPrevSel = sel;
    @(posedge clk);
    @(negedge clk);
    vectors++;
    if (outData !== expData) begin
      errors++;
      $display("FAIL %s sel=%0d mode=%0d idx=%0d: outData=%h expected %h",
               tagOf(sel), sel, um, idx, outData, expData);
    end
    vectors++;
    if (outValid !== expValid) begin
      errors++;
      $display("FAIL R2 sel=%0d idx=%0d: outValid=%b expected %b",
               sel, idx, outValid, expValid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, no sample taken yet
    vectors++;
    if (outData !== '0 || outValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: outData=%h outValid=%b expected 0000 0", outData, outValid);
    end

    for (int sel = 0; sel < 16; sel++) begin
      for (int um = 0; um < 4; um++) begin
        int len;
        if (sel != 8 && um != 0) continue;
        len = (sel == 5 || sel == 6) ? 600 : 40;
        for (int i = 0; i < len; i++) begin
          logic en;
          // Odd selects arrive on an idle clock, checking restart without a sample (R13)
          en = !((i % 7) == 3 || (i == 0 && sel[0]));
          // Each generator reset pulses at its own point: independence and reload (R8)
          step(en, 4'(sel), 2'(um), (i == len / 2), (i == len / 3 + 1),
               W'(i * 1234 + sel * 77), W'(16'h01A5 + i * 3 + um),
               W'(16'h3C0F ^ (i * 5)), i);
        end
      end
    end

    // R12: a mode change alone keeps the word index running
    for (int i = 0; i < 8; i++)
      step(1'b1, 4'd8, (i < 4) ? 2'd1 : 2'd3, 1'b0, 1'b0, '0,
           14'h0ABC, 14'h1DEF, i);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule